// File: doc/BRIEF.md
# Triggered SPI Pattern Player

This block sends one fixed SPI message each time it is triggered, without a processor and without a shift register. The whole waveform sits in a small internal pattern memory: every word holds one instant of the three SPI lines. Each chip-select transition, each clock level and each data bit is a separate stored word. A trigger edge sets a run latch. While the latch is set, an address counter steps through the memory at the rate of a clock-enable divider. When the address wraps, the latch is cleared, so a trigger always gives exactly one pass.

The pattern is computed at elaboration from a message parameter. It forms a 2-byte SPI mode-0 write, sent MSB first. A frame needs 2*MSG_BITS+3 words, and the remaining words keep the bus idle. The divider parameter and the pattern together set the SPI clock period: one SCLK period spans two words, which is 2*DIV system clocks. The memory has a registered read port and the pins are registered, so the lines follow the address by two clock cycles. `busy_o` is the run latch itself.

Top module: `spi_pattern_player`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `busy_o` is 0 and the pins show the idle state: `spi_csn_o`=1, `spi_sclk_o`=0, `spi_mosi_o`=0.
- R2: A 0-to-1 change of `start_i` while idle sets `busy_o` at the next clock edge. Holding `start_i` high starts no further pass.
- R3: A rising `start_i` while `busy_o` is high has no effect. `busy_o` only falls when the address wraps.
- R4: Once set, `busy_o` stays high for exactly DEPTH*DIV clock cycles.
- R5: The address advances by one every DIV cycles while busy. It is 0 whenever idle, so every pass replays the pattern from word 0.
- R6: Memory word bit 0 drives MOSI, bit 1 drives SCLK and bit 2 drives the active-low chip select. The pins lag the address by two cycles, so `spi_csn_o` first goes low DIV+2 cycles after `busy_o` rises (word 1 is the first word with chip select active).
- R7: When `busy_o` has been low for the current cycle and the two before it, the pins show the idle state, whatever the memory holds.
- R8: Each pass produces exactly one chip-select frame that carries 16 SCLK rising edges. On those edges MOSI carries MSG, MSB first. MOSI does not change on a rising edge, and SCLK is low whenever chip select changes (SPI mode 0).
- R9: After a pass ends, the pins return to idle within two cycles and stay idle until the next trigger.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Playback trigger, acts on its rising edge |
| busy_o | output | 1 | High while the run latch is set |
| spi_csn_o | output | 1 | SPI chip select, active low |
| spi_sclk_o | output | 1 | SPI serial clock |
| spi_mosi_o | output | 1 | SPI data out |

## Verification
The bound checker watches the sequencing on every cycle. It checks the start on a trigger edge and the refusal of a held level. It checks that `busy_o` can only fall at the address wrap, that the address holds between divider ticks and steps by one on a tick, that the address is zero while idle, and that the pins are forced idle after busy has been low long enough. Some behaviour only the bench scenarios can show. These are the decoded content of the frame, mode-0 data stability and chip-select framing, the exact pass length, and the delay from busy to chip select. The scenarios cover pulsed triggers, triggers held high and trigger toggling during a pass, each with random idle gaps.

// File: rtl/spp_pkg.sv
package spp_pkg;

  localparam int MOSI_BIT = 0;
  localparam int SCLK_BIT = 1;
  localparam int CSN_BIT  = 2;
  localparam int WORD_W   = 3;

  // Field order gives csn at bit 2, sclk at bit 1 and mosi at bit 0.
  typedef struct packed {
    logic csn;
    logic sclk;
    logic mosi;
  } spi_pins_t;

  localparam spi_pins_t PINS_IDLE = '{csn: 1'b1, sclk: 1'b0, mosi: 1'b0};

endpackage

// File: rtl/spp_trig_edge.sv
module spp_trig_edge (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  // Resets to 1 so that a trigger held through reset does not fire.
  always_ff @(posedge clk) begin
    if (rst) level_q <= 1'b1;
    else     level_q <= level_i;
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/spp_tick_gen.sv
module spp_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  output logic tick_o
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst || !en_i || tick_o) cnt_q <= '0;
    else                        cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spp_run_ctrl.sv
module spp_run_ctrl #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              tick_i,
  output logic              run_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam logic [ADDR_W-1:0] ADDR_LAST = ADDR_W'(DEPTH - 1);

  logic wrap;
  assign wrap = run_o && tick_i && (addr_o == ADDR_LAST);

  // Set/reset run latch: the trigger sets it, the address wrap clears it.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_o  <= 1'b0;
      addr_o <= '0;
    end else if (!run_o) begin
      addr_o <= '0;
      if (start_i) run_o <= 1'b1;
    end else if (wrap) begin
      run_o  <= 1'b0;
      addr_o <= '0;
    end else if (tick_i) begin
      addr_o <= addr_o + ADDR_W'(1);
    end
  end
endmodule

// File: rtl/spp_pattern_rom.sv
module spp_pattern_rom
  import spp_pkg::*;
#(
  parameter int                DEPTH    = 64,
  parameter int                ADDR_W   = 6,
  parameter int                MSG_BITS = 16,
  parameter logic [MSG_BITS-1:0] MSG    = 16'hA53C
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr_i,
  output spi_pins_t         data_q
);
  // Layout: word 0 idle, word 1 chip select low with the first bit set up,
  // then two words per bit (clock low, clock high), then one hold word with
  // the clock low, then idle until the end of the memory.
  localparam int BIT_WORDS = 2 * MSG_BITS;

  function automatic spi_pins_t word_at(input int idx);
    int rel;
    int bpos;
    spi_pins_t w;
    w   = PINS_IDLE;
    rel = idx - 2;
    if (idx == 1) begin
      w = '{csn: 1'b0, sclk: 1'b0, mosi: MSG[MSG_BITS-1]};
    end else if (idx >= 2 && rel < BIT_WORDS) begin
      bpos = MSG_BITS - 1 - rel / 2;
      w = '{csn: 1'b0, sclk: rel[0], mosi: MSG[bpos]};
    end else if (idx >= 2 && rel == BIT_WORDS) begin
      w = '{csn: 1'b0, sclk: 1'b0, mosi: 1'b0};
    end
    return w;
  endfunction

  spi_pins_t mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = word_at(i);
  end

  always_ff @(posedge clk) begin
    data_q <= mem[addr_i];
  end
endmodule

// File: rtl/spi_pattern_player.sv
module spi_pattern_player
  import spp_pkg::*;
#(
  parameter int                  DEPTH    = 64,
  parameter int                  DIV      = 4,
  parameter int                  MSG_BITS = 16,
  parameter logic [MSG_BITS-1:0] MSG      = 16'hA53C
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic spi_csn_o,
  output logic spi_sclk_o,
  output logic spi_mosi_o
);
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic              rise;
  logic              tick;
  logic              run;
  logic [ADDR_W-1:0] addr;
  spi_pins_t         rom_q;
  logic              run_q;
  spi_pins_t         pins_q;

  spp_trig_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .level_i (start_i),
    .rise_o  (rise)
  );

  spp_tick_gen #(.DIV(DIV)) u_tick (
    .clk    (clk),
    .rst    (rst),
    .en_i   (run),
    .tick_o (tick)
  );

  spp_run_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_run (
    .clk     (clk),
    .rst     (rst),
    .start_i (rise),
    .tick_i  (tick),
    .run_o   (run),
    .addr_o  (addr)
  );

  spp_pattern_rom #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .MSG_BITS(MSG_BITS), .MSG(MSG)
  ) u_rom (
    .clk    (clk),
    .addr_i (addr),
    .data_q (rom_q)
  );

  // run_q lines up with the registered memory word; the pins are forced
  // idle whenever that word was not read during a pass.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      pins_q <= PINS_IDLE;
    end else begin
      run_q  <= run;
      pins_q <= run_q ? rom_q : PINS_IDLE;
    end
  end

  assign busy_o     = run;
  assign spi_csn_o  = pins_q.csn;
  assign spi_sclk_o = pins_q.sclk;
  assign spi_mosi_o = pins_q.mosi;
endmodule

// File: rtl/spp_checker.sv
module spp_checker #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic              busy_o,
  input logic              spi_csn_o,
  input logic              spi_sclk_o,
  input logic              spi_mosi_o,
  input logic              tick,
  input logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!busy_o && spi_csn_o && !spi_sclk_o && !spi_mosi_o)); // R1

  AST_START_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i && !$past(start_i) && !$past(rst)) |=> busy_o); // R2

  AST_HELD_NO_START: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && start_i && $past(start_i)) |=> !busy_o); // R2

  AST_BUSY_ONLY_ENDS_AT_WRAP: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !(tick && addr == LAST)) |=> busy_o); // R3

  AST_WRAP_STOPS: assert property (@(posedge clk) disable iff (rst)
    (busy_o && tick && addr == LAST) |=> !busy_o); // R4

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
    (busy_o && !tick) |=> $stable(addr)); // R5

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (busy_o && tick && addr != LAST) |=> (addr == $past(addr) + ADDR_W'(1))); // R5

  AST_IDLE_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (addr == '0)); // R5

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !$past(busy_o) && !$past(busy_o, 2))
      |-> (spi_csn_o && !spi_sclk_o && !spi_mosi_o)); // R7
endmodule

bind spi_pattern_player spp_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .spi_csn_o  (spi_csn_o),
  .spi_sclk_o (spi_sclk_o),
  .spi_mosi_o (spi_mosi_o),
  .tick       (tick),
  .addr       (addr)
);

// File: tb/spi_pattern_player_tb.sv
module spi_pattern_player_tb;
  localparam int          CLK_PERIOD = 10;
  localparam int          DEPTH      = 64;
  localparam int          DIV        = 3;
  localparam int          MSG_BITS   = 16;
  localparam logic [15:0] MSG        = 16'hC35A;
  localparam int          PASS_CYC   = DEPTH * DIV;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic busy_o, spi_csn_o, spi_sclk_o, spi_mosi_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  spi_pattern_player #(
    .DEPTH(DEPTH), .DIV(DIV), .MSG_BITS(MSG_BITS), .MSG(MSG)
  ) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .busy_o(busy_o),
    .spi_csn_o(spi_csn_o), .spi_sclk_o(spi_sclk_o), .spi_mosi_o(spi_mosi_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Mode-0 decoder and idle monitor, sampling at the falling edge.
  int          frames = 0;
  int          bit_cnt = 0;
  logic [31:0] shreg = '0;
  logic [31:0] last_data = '0;
  int          last_bits = 0;
  int          mosi_moved = 0;
  int          csn_edge_bad = 0;
  int          idle_bad = 0;
  logic        csn_p = 1'b1, sclk_p = 1'b0, mosi_p = 1'b0;
  logic [2:0]  busy_h = '0;

  always @(negedge clk) begin
    if (!rst) begin
      busy_h = {busy_h[1:0], busy_o};
      if (!spi_csn_o && spi_sclk_o && !sclk_p) begin
        shreg = {shreg[30:0], spi_mosi_o};
        bit_cnt++;
        if (spi_mosi_o != mosi_p) mosi_moved++;
      end
      if (spi_csn_o != csn_p && (spi_sclk_o || sclk_p)) csn_edge_bad++;
      if (!spi_csn_o && csn_p) begin
        shreg = '0;
        bit_cnt = 0;
      end
      if (spi_csn_o && !csn_p) begin
        frames++;
        last_data = shreg;
        last_bits = bit_cnt;
      end
      if (busy_h == 3'b000 && !(spi_csn_o && !spi_sclk_o && !spi_mosi_o)) idle_bad++;
      csn_p  = spi_csn_o;
      sclk_p = spi_sclk_o;
      mosi_p = spi_mosi_o;
    end
  end

  function automatic logic [31:0] exp_frame();
    return {16'h0, MSG};
  endfunction

  // mode 0: single pulse, 1: held high, 2: random toggling while busy
  task automatic play(input int mode);
    int fr0 = frames;
    int cyc = 0;
    int first_cs = -1;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    chk(busy_o === 1'b1, "R2", "busy after trigger edge", busy_o, 1);
    if (mode == 0) start_i = 1'b0;
    while (busy_o && cyc < PASS_CYC + 20) begin
      if (!spi_csn_o && first_cs < 0) first_cs = cyc;
      if (mode == 2 && $urandom_range(0, 2) == 0) start_i = ~start_i;
      @(negedge clk);
      cyc++;
    end
    if (mode == 2) start_i = 1'b0;
    chk(cyc == PASS_CYC, mode == 2 ? "R3" : "R4", "busy length", cyc, PASS_CYC);
    chk(first_cs == DIV + 2, "R6", "chip select delay", first_cs, DIV + 2);
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0 && spi_csn_o === 1'b1 && spi_sclk_o === 1'b0 && spi_mosi_o === 1'b0,
        "R9", "idle after pass", {busy_o, spi_csn_o, spi_sclk_o, spi_mosi_o}, 4'b0100);
    chk(frames == fr0 + 1, "R8", "frames per pass", frames - fr0, 1);
    chk(last_data == exp_frame() && last_bits == MSG_BITS, "R8", "frame data",
        last_data, exp_frame());
    if (mode == 1) begin
      repeat (10) @(negedge clk);
      chk(busy_o === 1'b0, "R2", "held trigger no restart", busy_o, 0);
      start_i = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_checks + 1 - n_fail, n_checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (5) @(negedge clk);
    chk(busy_o === 1'b0 && spi_csn_o === 1'b1 && spi_sclk_o === 1'b0 && spi_mosi_o === 1'b0,
        "R1", "state in reset", {busy_o, spi_csn_o, spi_sclk_o, spi_mosi_o}, 4'b0100);
    rst = 1'b0;
    @(negedge clk);
    chk(busy_o === 1'b0 && spi_csn_o === 1'b1, "R1", "state after reset",
        {busy_o, spi_csn_o}, 2'b01);

    // Directed: pulse, held level, toggling during a pass (R3, R5 replay from word 0).
    play(0);
    play(1);
    play(2);
    for (int i = 0; i < 10; i++) begin
      repeat ($urandom_range(1, 20)) @(negedge clk);
      play(int'($urandom_range(0, 2)));
    end

    chk(mosi_moved == 0, "R8", "MOSI stable on SCLK rise", mosi_moved, 0);
    chk(csn_edge_bad == 0, "R8", "SCLK low at chip select edges", csn_edge_bad, 0);
    chk(idle_bad == 0, "R7", "idle pins while not busy", idle_bad, 0);
    chk(frames == 13, "R5", "one frame per pass overall", frames, 13);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule